// File: doc/BRIEF.md
# Thermal Cooldown Power Controller

This block guards a board against overheating. It watches two signed temperature readings: one from a sensor on the board, compared against a fixed limit of 85 °C, and one from a remote sensor such as a processor die, compared against a threshold supplied at an input (100 °C is a typical setting). When either reading goes above its limit while the board is powered and protection is enabled, the block drops its power-enable output. It then holds power off for a cooldown period, counted in one-second ticks.

The cooldown period backs off as events repeat. It starts at 5 s. Each trip uses the current period for its off time and then adds 30 s to it, with a ceiling of 300 s. Once the board has stayed powered for 300 enabled seconds without a trip, the period drops back to 5 s. A cause code tells which sensor caused the most recent trip, and the current cooldown value is brought out for observation.

Top module: `therm_cooldown_ctrl`

## Requirements
- R1: After reset, pwr_en is 1, trip_cause is 0 and cool_secs is 5.
- R2: While pwr_en is 1 and prot_en is 1, a cycle with loc_vld=1 and loc_temp strictly above 85 (signed) makes pwr_en 0 and trip_cause 4 from the next clock edge. A reading of exactly 85 does not trip.
- R3: Under the same conditions, a cycle with rem_vld=1 and rem_temp strictly above rem_limit (both signed) makes pwr_en 0 and trip_cause 5 from the next clock edge. A reading equal to the limit does not trip.
- R4: When the local and remote conditions are both true in the same cycle, trip_cause becomes 4.
- R5: The off period lasts exactly as many sec_tick pulses as cool_secs showed in the trip cycle. pwr_en returns to 1 on the edge that samples the last of those ticks.
- R6: On each trip, cool_secs becomes its old value plus 30 on the same edge that drops pwr_en. The first trip is therefore off for 5 s and the second for 35 s.
- R7: cool_secs never exceeds 300. A trip that would push it past 300 sets it to 300.
- R8: While power is on and protection is enabled, the 300th sec_tick without a trip sets cool_secs back to 5 on that edge. The count of ticks restarts each time power comes back on.
- R9: While prot_en is 0, no trip occurs and cool_secs holds its value. The quiet-time count is frozen and resumes where it stopped.
- R10: While pwr_en is 0, temperature inputs are ignored: trip_cause and cool_secs do not change.
- R11: A temperature reading with its valid strobe at 0 is ignored, whatever its value.
- R12: trip_cause keeps the code of the latest trip until the next trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Protection enable |
| loc_temp | input | TEMP_W | Board sensor reading, signed °C |
| loc_vld | input | 1 | Board reading valid strobe |
| rem_temp | input | TEMP_W | Remote sensor reading, signed °C |
| rem_vld | input | 1 | Remote reading valid strobe |
| rem_limit | input | TEMP_W | Remote trip threshold, signed °C |
| sec_tick | input | 1 | One-cycle pulse each second |
| pwr_en | output | 1 | Primary power enable |
| trip_cause | output | 3 | Last trip cause: 0 none, 4 local, 5 remote |
| cool_secs | output | COOL_W | Cooldown period for the next trip, seconds |

## Verification
A wrong off-time counter shows on pwr_en: power comes back a tick early or late, and this is visible on the very edge where the model expects the return. A corrupted backoff value shows on cool_secs on the edge of the trip that changes it. An error in the quiet counter stays hidden until a relaxation edge 300 ticks later, so the bench runs full quiet windows and compares cool_secs on every clock. A disable window falls inside one of these windows, which exposes a counter that fails to freeze.

// File: rtl/therm_cd_pkg.sv
package therm_cd_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_LOCAL  = 3'd4,
        CAUSE_REMOTE = 3'd5
    } trip_cause_e;

    typedef enum logic {
        ST_ON  = 1'b0,
        ST_OFF = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/therm_cd_trip.sv
module therm_cd_trip
    import therm_cd_pkg::*;
#(
    parameter int TEMP_W      = 12,
    parameter int LOCAL_LIMIT = 85
) (
    input  logic                     armed,
    input  logic signed [TEMP_W-1:0] loc_temp,
    input  logic                     loc_vld,
    input  logic signed [TEMP_W-1:0] rem_temp,
    input  logic                     rem_vld,
    input  logic signed [TEMP_W-1:0] rem_limit,
    output logic                     trip,
    output trip_cause_e              cause
);
    localparam logic signed [TEMP_W-1:0] LOC_LIM = TEMP_W'(LOCAL_LIMIT);

    logic loc_hot;
    logic rem_hot;

    always_comb begin
        loc_hot = armed && loc_vld && (loc_temp > LOC_LIM);
        rem_hot = armed && rem_vld && (rem_temp > rem_limit);
        trip    = loc_hot || rem_hot;
        if (loc_hot)      cause = CAUSE_LOCAL;
        else if (rem_hot) cause = CAUSE_REMOTE;
        else              cause = CAUSE_NONE;
    end
endmodule

// File: rtl/therm_cd_backoff.sv
module therm_cd_backoff #(
    parameter int COOL_MIN   = 5,
    parameter int COOL_STEP  = 30,
    parameter int COOL_MAX   = 300,
    parameter int QUIET_SECS = 300,
    localparam int COOL_W    = $clog2(COOL_MAX + 1),
    localparam int QUIET_W   = $clog2(QUIET_SECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              enable,
    input  logic              trip,
    input  logic              sec_tick,
    output logic [COOL_W-1:0] cool
);
    typedef struct packed {
        logic [COOL_W-1:0]  cool;
        logic [QUIET_W-1:0] quiet;
    } bo_t;

    bo_t             r_q, r_d;
    logic [COOL_W:0] bumped;

    always_comb begin
        r_d    = r_q;
        bumped = {1'b0, r_q.cool} + (COOL_W + 1)'(COOL_STEP);
        if (!pwr_on) begin
            r_d.quiet = '0;
        end else if (trip) begin
            r_d.quiet = '0;
            r_d.cool  = (bumped > (COOL_W + 1)'(COOL_MAX)) ? COOL_W'(COOL_MAX)
                                                           : bumped[COOL_W-1:0];
        end else if (enable && sec_tick && r_q.quiet != QUIET_W'(QUIET_SECS)) begin
            r_d.quiet = r_q.quiet + 1'b1;
            if (r_q.quiet == QUIET_W'(QUIET_SECS - 1))
                r_d.cool = COOL_W'(COOL_MIN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cool  <= COOL_W'(COOL_MIN);
            r_q.quiet <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cool = r_q.cool;
endmodule

// File: rtl/therm_cooldown_ctrl.sv
module therm_cooldown_ctrl
    import therm_cd_pkg::*;
#(
    parameter int TEMP_W      = 12,
    parameter int LOCAL_LIMIT = 85,
    parameter int COOL_MIN    = 5,
    parameter int COOL_STEP   = 30,
    parameter int COOL_MAX    = 300,
    parameter int QUIET_SECS  = 300,
    localparam int COOL_W     = $clog2(COOL_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prot_en,
    input  logic signed [TEMP_W-1:0] loc_temp,
    input  logic                     loc_vld,
    input  logic signed [TEMP_W-1:0] rem_temp,
    input  logic                     rem_vld,
    input  logic signed [TEMP_W-1:0] rem_limit,
    input  logic                     sec_tick,
    output logic                     pwr_en,
    output logic [2:0]               trip_cause,
    output logic [COOL_W-1:0]        cool_secs
);
    typedef struct packed {
        pwr_state_e        st;
        logic [COOL_W-1:0] remain;
        trip_cause_e       cause;
    } ctl_t;

    ctl_t              s_q, s_d;
    logic              armed;
    logic              trip;
    trip_cause_e       new_cause;
    logic [COOL_W-1:0] cool_cur;

    assign armed = (s_q.st == ST_ON) && prot_en;

    therm_cd_trip #(
        .TEMP_W      (TEMP_W),
        .LOCAL_LIMIT (LOCAL_LIMIT)
    ) u_trip (
        .armed     (armed),
        .loc_temp  (loc_temp),
        .loc_vld   (loc_vld),
        .rem_temp  (rem_temp),
        .rem_vld   (rem_vld),
        .rem_limit (rem_limit),
        .trip      (trip),
        .cause     (new_cause)
    );

    therm_cd_backoff #(
        .COOL_MIN   (COOL_MIN),
        .COOL_STEP  (COOL_STEP),
        .COOL_MAX   (COOL_MAX),
        .QUIET_SECS (QUIET_SECS)
    ) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (s_q.st == ST_ON),
        .enable   (prot_en),
        .trip     (trip),
        .sec_tick (sec_tick),
        .cool     (cool_cur)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_ON: begin
                if (trip) begin
                    s_d.st     = ST_OFF;
                    s_d.remain = cool_cur;
                    s_d.cause  = new_cause;
                end
            end
            ST_OFF: begin
                if (sec_tick) begin
                    if (s_q.remain <= COOL_W'(1)) begin
                        s_d.st     = ST_ON;
                        s_d.remain = '0;
                    end else begin
                        s_d.remain = s_q.remain - 1'b1;
                    end
                end
            end
            default: s_d.st = ST_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st     <= ST_ON;
            s_q.remain <= '0;
            s_q.cause  <= CAUSE_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwr_en     = (s_q.st == ST_ON);
    assign trip_cause = s_q.cause;
    assign cool_secs  = cool_cur;
endmodule

// File: rtl/therm_cd_chk.sv
module therm_cd_chk #(
    parameter int TEMP_W      = 12,
    parameter int LOCAL_LIMIT = 85,
    parameter int COOL_MIN    = 5,
    parameter int COOL_STEP   = 30,
    parameter int COOL_MAX    = 300,
    localparam int COOL_W     = $clog2(COOL_MAX + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     prot_en,
    input logic signed [TEMP_W-1:0] loc_temp,
    input logic                     loc_vld,
    input logic signed [TEMP_W-1:0] rem_temp,
    input logic                     rem_vld,
    input logic signed [TEMP_W-1:0] rem_limit,
    input logic                     sec_tick,
    input logic                     pwr_en,
    input logic [2:0]               trip_cause,
    input logic [COOL_W-1:0]        cool_secs
);
    localparam logic signed [TEMP_W-1:0] LOC_LIM = TEMP_W'(LOCAL_LIMIT);

    logic loc_hot, rem_hot;
    assign loc_hot = loc_vld && (loc_temp > LOC_LIM);
    assign rem_hot = rem_vld && (rem_temp > rem_limit);

    p_local_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && prot_en && loc_hot) |=> (!pwr_en && trip_cause == 3'd4));

    p_remote_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && prot_en && !loc_hot && rem_hot) |=> (!pwr_en && trip_cause == 3'd5));

    p_return_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !sec_tick) |=> !pwr_en);

    p_step_on_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (int'(cool_secs) ==
            ((int'($past(cool_secs)) + COOL_STEP > COOL_MAX) ? COOL_MAX
                                                             : int'($past(cool_secs)) + COOL_STEP)));

    p_cool_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cool_secs) >= COOL_MIN && int'(cool_secs) <= COOL_MAX));

    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !prot_en) |=> (pwr_en && $stable(cool_secs)));

    p_off_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> ($stable(cool_secs) && $stable(trip_cause)));

    p_cause_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !(prot_en && (loc_hot || rem_hot))) |=> $stable(trip_cause));
endmodule

bind therm_cooldown_ctrl therm_cd_chk #(
    .TEMP_W      (TEMP_W),
    .LOCAL_LIMIT (LOCAL_LIMIT),
    .COOL_MIN    (COOL_MIN),
    .COOL_STEP   (COOL_STEP),
    .COOL_MAX    (COOL_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prot_en    (prot_en),
    .loc_temp   (loc_temp),
    .loc_vld    (loc_vld),
    .rem_temp   (rem_temp),
    .rem_vld    (rem_vld),
    .rem_limit  (rem_limit),
    .sec_tick   (sec_tick),
    .pwr_en     (pwr_en),
    .trip_cause (trip_cause),
    .cool_secs  (cool_secs)
);

// File: tb/therm_cooldown_ctrl_tb.sv
module therm_cooldown_ctrl_tb;
    localparam int TW = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 prot_en = 1'b1;
    logic signed [TW-1:0] loc_temp = '0;
    logic                 loc_vld = 1'b0;
    logic signed [TW-1:0] rem_temp = '0;
    logic                 rem_vld = 1'b0;
    logic signed [TW-1:0] rem_limit = TW'(100);
    logic                 sec_tick = 1'b0;
    logic                 pwr_en;
    logic [2:0]           trip_cause;
    logic [8:0]           cool_secs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_div = 1;
    int phase = 0;

    // behavioural reference state
    bit m_on = 1'b1;
    int m_rem = 0;
    int m_cool = 5;
    int m_quiet = 0;
    int m_cause = 0;

    therm_cooldown_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_en    (prot_en),
        .loc_temp   (loc_temp),
        .loc_vld    (loc_vld),
        .rem_temp   (rem_temp),
        .rem_vld    (rem_vld),
        .rem_limit  (rem_limit),
        .sec_tick   (sec_tick),
        .pwr_en     (pwr_en),
        .trip_cause (trip_cause),
        .cool_secs  (cool_secs)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic model_update();
        bit lt, rt;
        if (m_on) begin
            lt = prot_en && loc_vld && (int'(loc_temp) > 85);
            rt = prot_en && rem_vld && (int'(rem_temp) > int'(rem_limit));
            if (lt || rt) begin
                m_on    = 1'b0;
                m_rem   = m_cool;
                m_cause = lt ? 4 : 5;
                m_cool  = (m_cool + 30 > 300) ? 300 : m_cool + 30;
                m_quiet = 0;
            end else if (prot_en && sec_tick && m_quiet < 300) begin
                m_quiet++;
                if (m_quiet == 300) m_cool = 5;
            end
        end else begin
            m_quiet = 0;
            if (sec_tick) begin
                m_rem--;
                if (m_rem == 0) m_on = 1'b1;
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (pwr_en !== m_on || int'(trip_cause) != m_cause || int'(cool_secs) != m_cool) begin
            errors++;
            $display("FAIL %s: actual pwr=%0b cause=%0d cool=%0d expected pwr=%0b cause=%0d cool=%0d",
                     tag, pwr_en, trip_cause, cool_secs, m_on, m_cause, m_cool);
        end
    endtask

    task automatic step(string tag);
        sec_tick = (tick_div <= 1) ? 1'b1 : ((phase % tick_div) == 0);
        phase++;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic quiet_inputs();
        loc_vld = 1'b0; rem_vld = 1'b0; loc_temp = '0; rem_temp = '0;
    endtask

    task automatic spot(string tag, int expect_cool);
        checks++;
        if (int'(cool_secs) != expect_cool) begin
            errors++;
            $display("FAIL %s: actual cool=%0d expected cool=%0d", tag, cool_secs, expect_cool);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        // R11: hot reading without strobe
        loc_temp = TW'(120); loc_vld = 1'b0;
        run(4, "R11 invalid ignored");
        // R2 boundary: exactly 85
        loc_temp = TW'(85); loc_vld = 1'b1;
        run(4, "R2 at limit no trip");
        // R2: local trip
        loc_temp = TW'(86);
        tick_div = 3;
        step("R2 local trip");
        spot("R6 first step", 35);
        // R10: hot inputs while off
        rem_temp = TW'(150); rem_vld = 1'b1;
        run(6, "R10 off ignores temps");
        quiet_inputs();
        run(20, "R5 off duration");

        // R3: remote boundary and trip
        tick_div = 1;
        rem_temp = TW'(100); rem_vld = 1'b1;
        run(2, "R3 at limit no trip");
        rem_temp = TW'(101);
        step("R3 remote trip");
        quiet_inputs();
        run(40, "R6 second off 35");

        // R4: both at once, negative limit too
        rem_limit = -TW'(5); rem_temp = -TW'(4); rem_vld = 1'b1;
        loc_temp = TW'(90); loc_vld = 1'b1;
        step("R4 local priority");
        quiet_inputs();
        rem_limit = TW'(100);
        run(70, "R4 recovery");
        run(5, "R12 cause held");

        // R9: disabled, hot inputs, many ticks
        prot_en = 1'b0;
        loc_temp = TW'(200); loc_vld = 1'b1;
        rem_temp = TW'(200); rem_vld = 1'b1;
        run(400, "R9 disabled no trip");
        spot("R9 cool held", 95);
        quiet_inputs();
        prot_en = 1'b1;

        // R8: quiet window relaxes
        run(310, "R8 relax");
        spot("R8 back to min", 5);

        // R7: repeated trips up to cap
        for (int k = 0; k < 12; k++) begin
            loc_temp = TW'(100); loc_vld = 1'b1;
            step("R7 trip");
            quiet_inputs();
            while (!m_on) step("R7 off");
            step("R7 on");
        end
        spot("R7 capped", 300);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule